// File: doc/BRIEF.md
# Audio Frame and Bit Clock Divider

This block turns a master audio clock into the two timing clocks that a stereo serial audio port needs when it drives the bus: a frame clock at the sample rate Fs and a bit clock at 32 × Fs. Its input is a small set of configuration fields. The first is a speed mode (single, double or quad rate). The second is a ratio code that gives how many master-clock cycles make up one frame. The third is a power-down bit. The block divides the master clock by that ratio, so one frame is exactly `ratio` master-clock cycles long.

Each speed mode accepts only five of the nine ratios. A combination outside that set raises an error flag and keeps both clocks low. The power-down bit is set after reset. Software therefore writes the format first and then clears power-down to start the clocks. A format written while the clocks run waits in a programmed copy. That copy becomes active only when the current frame ends, so no output pulse is ever cut short.

Top module: `fs_clock_gen`

## Requirements
- R1: While `rst_n` is low, the power-down bit is forced to 1 and the format to single speed with ratio code 4 (256), both in the programmed and in the active copy. Both clocks are low and `cfg_err_o` is 0 during reset. Clearing power-down after reset, with no format write, gives a bit period of 8 master cycles.
- R2: While power-down is 1, `bclk_o` and `frame_clk_o` stay low. Format writes made in that time are kept and are used when power-down is cleared.
- R3: Power-down is cleared by the write that takes effect at master edge E. Counting the state after E as cycle 0, the frame clock is low for the first 16 bit periods and high for the next 16, so one frame is 32 bit periods (the full ratio). The pattern then repeats.
- R4: One bit period is P = ratio / 32 master cycles. Within each period, `bclk_o` is low for the first ceil(P/2) cycles and high for the remaining floor(P/2) cycles. The first period of a run begins low. For P = 3 this means low 2 cycles and high 1.
- R5: Ratio code encoding (4 bits): 0→64, 1→96, 2→128, 3→192, 4→256, 5→384, 6→512, 7→768, 8→1024. Codes 9 to 15 are never legal.
- R6: Speed encoding (2 bits): 0 single, 1 double, 2 quad, 3 reserved and never legal. Legal codes are 4..8 in single, 2..6 in double and 0..4 in quad.
- R7: `cfg_err_o` is 1 whenever the active format is not legal. In that state both clocks are low even with power-down cleared. A format written while power-down is 1 shows its legality on `cfg_err_o` in the cycle after the write edge.
- R8: A format write made while the clocks run leaves the current frame unchanged. The new format takes effect at the first bit period of the next frame, including its error flag.
- R9: Setting power-down while the clocks run drives both clocks low in the cycle after the write edge. Clearing it again restarts at cycle 0 of a frame, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to defaults |
| pdn_we | input | 1 | Write strobe for the power-down bit |
| pdn_wdata | input | 1 | New power-down value (1 = clocks idle) |
| fmt_we | input | 1 | Write strobe for the format fields |
| speed_wdata | input | 2 | New speed mode code (R6) |
| ratio_wdata | input | 4 | New ratio code (R5) |
| bclk_o | output | 1 | Bit clock, 32 periods per frame |
| frame_clk_o | output | 1 | Frame clock at Fs, low in the first half of the frame |
| cfg_err_o | output | 1 | Active format is illegal for its speed mode |

## Verification
Suppose the bit phase counter holds a wrong value, for example because it wraps at the wrong count or resets at the wrong moment. Then a `bclk_o` edge moves within one bit period, at most 32 master cycles after the fault. A wrong frame position count shows as a shifted `frame_clk_o` edge within half a frame. An active format latched mid-frame, or never latched, shows as a period change at the wrong cycle or one that never comes; the bench catches this by writing formats partway through a frame and comparing every cycle across the boundary. A wrong legality decode or power-down path shows on `cfg_err_o` or as clocks that fail to stop, within one cycle of the write edge.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

  localparam int CODE_W     = 4;
  localparam int RATIO_W    = 11;
  localparam int NUM_CODES  = 9;
  localparam int RATIO_SPAN = 5;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_RSVD   = 2'd3
  } speed_e;

  typedef struct packed {
    speed_e              speed;
    logic [CODE_W-1:0]   code;
  } fmt_t;

  localparam fmt_t FMT_DEFAULT = '{speed: SPD_SINGLE, code: 4'd4};

  // Master cycles per frame: even codes are 64 times a power of two,
  // odd codes are 96 times a power of two.
  function automatic logic [RATIO_W-1:0] ratio_of(logic [CODE_W-1:0] code);
    logic [RATIO_W-1:0] base;
    if (code >= CODE_W'(NUM_CODES)) return '0;
    base = code[0] ? RATIO_W'(96) : RATIO_W'(64);
    return base << code[CODE_W-1:1];
  endfunction

  // Smallest code accepted by each speed mode; five codes are legal from it.
  function automatic logic [CODE_W-1:0] lowest_code(speed_e s);
    case (s)
      SPD_SINGLE: return CODE_W'(4);
      SPD_DOUBLE: return CODE_W'(2);
      default:    return CODE_W'(0);
    endcase
  endfunction

  function automatic logic fmt_legal(fmt_t f);
    logic [CODE_W-1:0] lo;
    if (f.speed == SPD_RSVD) return 1'b0;
    lo = lowest_code(f.speed);
    return (f.code >= lo) && (f.code <= lo + CODE_W'(RATIO_SPAN - 1));
  endfunction

  // Master cycles per bit clock period.
  function automatic logic [RATIO_W-1:0] bit_period(fmt_t f, int unsigned log2_bits);
    logic [RATIO_W-1:0] r;
    r = ratio_of(f.code);
    return r >> log2_bits;
  endfunction

  // First phase index at which the bit clock is high (low part is the longer one).
  function automatic logic [RATIO_W-1:0] high_from(logic [RATIO_W-1:0] period);
    return (period + RATIO_W'(1)) >> 1;
  endfunction

endpackage

// File: rtl/fcg_cfg_regs.sv
module fcg_cfg_regs
  import fcg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pdn_we,
  input  logic pdn_wdata,
  input  logic fmt_we,
  input  fmt_t fmt_wdata,
  input  logic load_act,
  output logic pdn_q,
  output fmt_t act_q
);

  fmt_t prog_q;
  fmt_t fmt_next;

  // The value the programmed copy holds after this edge; the active copy
  // takes it directly so a write in the same cycle as a load is not lost.
  always_comb fmt_next = fmt_we ? fmt_wdata : prog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdn_q  <= 1'b1;
      prog_q <= FMT_DEFAULT;
      act_q  <= FMT_DEFAULT;
    end else begin
      if (pdn_we) pdn_q <= pdn_wdata;
      prog_q <= fmt_next;
      if (load_act) act_q <= fmt_next;
    end
  end

endmodule

// File: rtl/fcg_bit_phase.sv
module fcg_bit_phase
  import fcg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RATIO_W-1:0] period,
  output logic [RATIO_W-1:0] phase_q,
  output logic               phase_wrap,
  output logic               bclk
);

  logic [RATIO_W-1:0] hi_start;

  always_comb begin
    hi_start   = high_from(period);
    phase_wrap = run && (phase_q == period - RATIO_W'(1));
    bclk       = run && (phase_q >= hi_start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   phase_q <= '0;
    else if (!run || phase_wrap)  phase_q <= '0;
    else                          phase_q <= phase_q + RATIO_W'(1);
  end

endmodule

// File: rtl/fcg_frame_pos.sv
module fcg_frame_pos #(
  parameter int BITS_PER_FRAME = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic phase_wrap,
  output logic [$clog2(BITS_PER_FRAME)-1:0] bit_q,
  output logic frame_end,
  output logic frame_clk
);

  localparam int BIT_W = $clog2(BITS_PER_FRAME);
  localparam int HALF  = BITS_PER_FRAME / 2;

  always_comb begin
    frame_end = phase_wrap && (bit_q == BIT_W'(BITS_PER_FRAME - 1));
    frame_clk = run && (bit_q >= BIT_W'(HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bit_q <= '0;
    else if (!run)       bit_q <= '0;
    else if (frame_end)  bit_q <= '0;
    else if (phase_wrap) bit_q <= bit_q + BIT_W'(1);
  end

endmodule

// File: rtl/fs_clock_gen.sv
module fs_clock_gen
  import fcg_pkg::*;
#(
  parameter int BITS_PER_FRAME = 32
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       pdn_we,
  input  logic       pdn_wdata,
  input  logic       fmt_we,
  input  logic [1:0] speed_wdata,
  input  logic [3:0] ratio_wdata,
  output logic       bclk_o,
  output logic       frame_clk_o,
  output logic       cfg_err_o
);

  localparam int LOG2_BITS = $clog2(BITS_PER_FRAME);

  // Named internal events, observed by the bound checker.
  fmt_t               wr_fmt;
  fmt_t               act_fmt;
  logic               pdn_q;
  logic               cfg_err;
  logic               run;
  logic               load_act;
  logic               phase_wrap;
  logic               frame_end;
  logic [RATIO_W-1:0] period;
  logic [RATIO_W-1:0] phase_q;
  logic [LOG2_BITS-1:0] bit_q;
  logic               bclk;
  logic               frame_clk;

  always_comb begin
    wr_fmt.speed = speed_e'(speed_wdata);
    wr_fmt.code  = ratio_wdata;
    cfg_err      = !fmt_legal(act_fmt);
    run          = !pdn_q && !cfg_err;
    load_act     = !run || frame_end;
    period       = bit_period(act_fmt, LOG2_BITS);
  end

  fcg_cfg_regs u_cfg (
    .clk       (mclk),
    .rst_n     (rst_n),
    .pdn_we    (pdn_we),
    .pdn_wdata (pdn_wdata),
    .fmt_we    (fmt_we),
    .fmt_wdata (wr_fmt),
    .load_act  (load_act),
    .pdn_q     (pdn_q),
    .act_q     (act_fmt)
  );

  fcg_bit_phase u_phase (
    .clk        (mclk),
    .rst_n      (rst_n),
    .run        (run),
    .period     (period),
    .phase_q    (phase_q),
    .phase_wrap (phase_wrap),
    .bclk       (bclk)
  );

  fcg_frame_pos #(.BITS_PER_FRAME(BITS_PER_FRAME)) u_frame (
    .clk        (mclk),
    .rst_n      (rst_n),
    .run        (run),
    .phase_wrap (phase_wrap),
    .bit_q      (bit_q),
    .frame_end  (frame_end),
    .frame_clk  (frame_clk)
  );

  assign bclk_o      = bclk;
  assign frame_clk_o = frame_clk;
  assign cfg_err_o   = cfg_err;

endmodule

// File: rtl/fcg_checker.sv
module fcg_checker
  import fcg_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic pdn_q,
  input logic run,
  input logic cfg_err,
  input logic frame_end,
  input logic phase_wrap,
  input logic bclk,
  input logic frame_clk,
  input fmt_t act_fmt
);

  p_idle_in_powerdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_q |-> (!bclk && !frame_clk));

  p_error_silences_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!bclk && !frame_clk));

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (!bclk && !frame_clk));

  p_frame_moves_on_bit_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(frame_clk)) |-> $past(phase_wrap));

  p_fmt_held_midframe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(frame_end)) |-> $stable(act_fmt));

  p_restart_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pdn_q) |-> (!bclk && !frame_clk));

endmodule

bind fs_clock_gen fcg_checker u_fcg_checker (
  .clk        (mclk),
  .rst_n      (rst_n),
  .pdn_q      (pdn_q),
  .run        (run),
  .cfg_err    (cfg_err),
  .frame_end  (frame_end),
  .phase_wrap (phase_wrap),
  .bclk       (bclk),
  .frame_clk  (frame_clk),
  .act_fmt    (act_fmt)
);

// File: tb/fs_clock_gen_bench.sv
module fs_clock_gen_bench;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdn_we = 1'b0;
  logic       pdn_wdata = 1'b0;
  logic       fmt_we = 1'b0;
  logic [1:0] speed_wdata = 2'd0;
  logic [3:0] ratio_wdata = 4'd0;
  logic       bclk_o;
  logic       frame_clk_o;
  logic       cfg_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 mclk = ~mclk;

  fs_clock_gen u_fs_clock_gen (
    .mclk        (mclk),
    .rst_n       (rst_n),
    .pdn_we      (pdn_we),
    .pdn_wdata   (pdn_wdata),
    .fmt_we      (fmt_we),
    .speed_wdata (speed_wdata),
    .ratio_wdata (ratio_wdata),
    .bclk_o      (bclk_o),
    .frame_clk_o (frame_clk_o),
    .cfg_err_o   (cfg_err_o)
  );

  // Bit period in master cycles for each ratio code (R5: ratio / 32).
  function automatic int p_of(int code);
    case (code)
      0: return 2;  1: return 3;  2: return 4;  3: return 6;  4: return 8;
      5: return 12; 6: return 16; 7: return 24; 8: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_b(int p, int s);
    return (s % p) >= ((p + 1) / 2);
  endfunction

  function automatic bit exp_l(int p, int s);
    return ((s / p) % 32) >= 16;
  endfunction

  task automatic expect3(bit eb, bit el, bit ee, string req);
    n_cmp++;
    if (bclk_o !== eb || frame_clk_o !== el || cfg_err_o !== ee) begin
      n_bad++;
      if (n_bad <= 20)
        $display("FAIL %s at %0t: bclk/frame/err actual %b%b%b expected %b%b%b",
                 req, $time, bclk_o, frame_clk_o, cfg_err_o, eb, el, ee);
    end
  endtask

  task automatic write_pdn(bit v);
    @(negedge mclk); pdn_we = 1'b1; pdn_wdata = v;
    @(negedge mclk); pdn_we = 1'b0;
  endtask

  task automatic put_fmt(int sp, int code);
    fmt_we = 1'b1; speed_wdata = 2'(sp); ratio_wdata = 4'(code);
  endtask

  task automatic write_fmt(int sp, int code);
    @(negedge mclk); put_fmt(sp, code);
    @(negedge mclk); fmt_we = 1'b0;
  endtask

  task automatic track(int p, int n, string req);
    for (int s = 0; s < n; s++) begin
      expect3(exp_b(p, s), exp_l(p, s), 1'b0, req);
      @(negedge mclk);
    end
  endtask

  task automatic hold_low(int n, bit ee, string req);
    for (int s = 0; s < n; s++) begin
      expect3(1'b0, 1'b0, ee, req);
      @(negedge mclk);
    end
  endtask

  // R1: reset state and idle after release.
  task automatic t_reset_state();
    repeat (4) @(negedge mclk);
    expect3(1'b0, 1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge mclk);
    hold_low(40, 1'b0, "R1 idle after reset");
  endtask

  // R1, R3, R4: default format 256 gives P = 8; then R9 stop.
  task automatic t_defaults();
    write_pdn(1'b0);
    track(8, 2 * 256 + 5, "R1 R3 default run");
    write_pdn(1'b1);
    hold_low(20, 1'b0, "R9 stop");
  endtask

  // R2, R4: program while idle, then the odd period 3.
  task automatic t_program_in_pd();
    write_fmt(2, 1);
    hold_low(50, 1'b0, "R2 idle while programmed");
    write_pdn(1'b0);
    track(3, 2 * 96, "R4 period 3 duty");
    write_pdn(1'b1);
  endtask

  // R5, R6: legal formats in each speed mode.
  task automatic t_mode_sweep();
    int sp [7] = '{0, 0, 1, 1, 2, 2, 1};
    int cd [7] = '{8, 7, 2, 5, 0, 4, 6};
    for (int i = 0; i < 7; i++) begin
      write_fmt(sp[i], cd[i]);
      hold_low(3, 1'b0, "R2 idle before start");
      write_pdn(1'b0);
      track(p_of(cd[i]), 32 * p_of(cd[i]) + 3, "R5 R6 ratio sweep");
      write_pdn(1'b1);
    end
  endtask

  // R6, R7: legality decode while idle, then illegal with power-down cleared.
  task automatic t_legality();
    int sp [9] = '{0, 1, 2, 1, 2, 3, 1, 0, 0};
    int cd [9] = '{4, 6, 4, 2, 5, 4, 9, 3, 0};
    bit ok [9] = '{1, 1, 1, 1, 0, 0, 0, 0, 0};
    for (int i = 0; i < 9; i++) begin
      write_fmt(sp[i], cd[i]);
      expect3(1'b0, 1'b0, !ok[i], "R6 R7 legality flag");
    end
    write_pdn(1'b0);
    hold_low(100, 1'b1, "R7 illegal holds clocks low");
    write_pdn(1'b1);
  endtask

  // R8: change from P = 2 to P = 4 written mid-frame.
  task automatic t_boundary_switch();
    write_fmt(2, 0);
    write_pdn(1'b0);
    for (int s = 0; s < 64 + 300; s++) begin
      int p;
      int ss;
      p  = (s < 64) ? 2 : 4;
      ss = (s < 64) ? s : s - 64;
      expect3(exp_b(p, ss), exp_l(p, ss), 1'b0, "R8 change at frame boundary");
      if (s == 10) put_fmt(2, 2);
      if (s == 11) fmt_we = 1'b0;
      @(negedge mclk);
    end
    write_pdn(1'b1);
  endtask

  // R7, R8: illegal format written mid-frame takes effect at the boundary.
  task automatic t_illegal_midrun();
    write_fmt(2, 2);
    write_pdn(1'b0);
    for (int s = 0; s < 140; s++) begin
      if (s < 128) expect3(exp_b(4, s), exp_l(4, s), 1'b0, "R7 R8 old frame kept");
      else         expect3(1'b0, 1'b0, 1'b1, "R7 error after boundary");
      if (s == 5) put_fmt(0, 0);
      if (s == 6) fmt_we = 1'b0;
      @(negedge mclk);
    end
    write_pdn(1'b1);
  endtask

  // R9: power-down mid-run, then restart from the frame start.
  task automatic t_pd_midrun();
    write_fmt(1, 3);
    write_pdn(1'b0);
    track(6, 100, "R9 before stop");
    pdn_we = 1'b1; pdn_wdata = 1'b1;
    @(negedge mclk);
    pdn_we = 1'b0;
    hold_low(10, 1'b0, "R9 stopped next cycle");
    write_pdn(1'b0);
    track(6, 2 * 192, "R9 restart at frame start");
  endtask

  // R1: reset while running restores defaults.
  task automatic t_reset_midrun();
    rst_n = 1'b0;
    @(negedge mclk);
    expect3(1'b0, 1'b0, 1'b0, "R1 reset while running");
    rst_n = 1'b1;
    @(negedge mclk);
    hold_low(10, 1'b0, "R1 power-down restored");
    write_pdn(1'b0);
    track(8, 300, "R1 default format restored");
    write_pdn(1'b1);
  endtask

  initial begin
    t_reset_state();
    t_defaults();
    t_program_in_pd();
    t_mode_sweep();
    t_legality();
    t_boundary_switch();
    t_illegal_midrun();
    t_pd_midrun();
    t_reset_midrun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mclk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual still running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule